// File: doc/BRIEF.md
# Strobed Memory Bus Master

This block runs single read and write transfers against a memory that has no ready or acknowledge line. The memory sees a 12-bit address, an 8-bit data path, one direction line (0 = read, 1 = write) and an enable strobe. All timing comes from the master: it presents address and direction, waits a fixed number of setup clocks, raises enable for a fixed number of access clocks, and then ends the transfer.

A client starts a transfer with a one-clock `start_i` pulse. With it come the read/write select, the address and the write data. `busy_o` stays high from the clock after acceptance until the transfer finishes. `done_o` pulses for one clock at the end, and for reads `rdata_o` then holds the captured byte.

The sequencer has four states. It sits in IDLE until a start is accepted (transition IDLE->SETUP). It stays in SETUP for `SETUP_CYC` clocks with enable low, then moves SETUP->ACCESS. It stays in ACCESS for `ACCESS_CYC` clocks with enable high, then moves ACCESS->DONE, capturing read data on that edge. It spends one clock in DONE and then returns DONE->IDLE.

Top module: `strobe_mem_master`

## Requirements
- R1: While reset is held and just after its release, `mem_en_o`, `mem_doe_o`, `done_o` and `busy_o` are 0 and `mem_rdwr_o` is 0.
- R2: Once a start is accepted, `mem_addr_o` and `mem_rdwr_o` carry the request from the next clock. `mem_en_o` then stays low for exactly `SETUP_CYC` clocks (parameter, at least 1).
- R3: After setup, `mem_en_o` is high for exactly `ACCESS_CYC` consecutive clocks (parameter, at least 1) and is then low again.
- R4: `mem_addr_o` and `mem_rdwr_o` do not change while `busy_o` is high.
- R5: On a read, `rdata_o` takes the value of `mem_din_i` present on the last enabled clock. It keeps that value through later writes, until the next read completes.
- R6: `mem_doe_o` is high only during the setup and access clocks of a write, and then `mem_dout_o` equals the requested write data. It is low at every other time.
- R7: `done_o` is high for exactly one clock, the clock right after the last enabled clock. `busy_o` is high from the clock after acceptance through the done clock, and low on the clock after that.
- R8: A start pulse that arrives while `busy_o` is high is ignored: no second transfer follows.
- R9: `mem_rdwr_o` is 1 for write transfers and 0 for read transfers. It returns to 0 when the master is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to begin a transfer |
| wr_sel_i | input | 1 | 1 = write transfer, 0 = read transfer |
| addr_i | input | 12 | Transfer address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Last captured read byte |
| done_o | output | 1 | One-clock end-of-transfer pulse |
| busy_o | output | 1 | Transfer in progress |
| mem_rdwr_o | output | 1 | Memory direction line, 0 read / 1 write |
| mem_en_o | output | 1 | Memory enable strobe |
| mem_addr_o | output | 12 | Memory address |
| mem_dout_o | output | 8 | Data driven toward memory |
| mem_doe_o | output | 1 | Output enable for `mem_dout_o` |
| mem_din_i | input | 8 | Data returned by memory |

## Verification
The assertions assume that the memory delivers valid read data by the last enabled clock, and that a client starts a transfer only with a single-clock pulse. The bench memory model deliberately returns the inverted byte on every enabled clock except the last one. This makes the capture point visible at the ports. Requests are driven on the falling edge and removed one clock later. Extra start pulses are injected only while the master is busy, which exercises the ignore rule without ever issuing two starts in one idle clock.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DONE   = 2'd3
    } sbm_state_e;
endpackage

// File: rtl/sbm_interval_ctr.sv
module sbm_interval_ctr #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

    // R3
    dec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sbm_cycle_fsm.sv
module sbm_cycle_fsm
    import sbm_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int ACCESS_CYC = 3,
    parameter int CW         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          ctr_last_i,
    output sbm_state_e    state_o,
    output logic          accept_o,
    output logic          capture_o,
    output logic          ctr_load_o,
    output logic [CW-1:0] ctr_val_o,
    output logic          ctr_dec_o
);
    localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] ACCESS_LAST = CW'(ACCESS_CYC - 1);

    sbm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)    state_d = ST_SETUP;
            ST_SETUP:  if (ctr_last_i) state_d = ST_ACCESS;
            ST_ACCESS: if (ctr_last_i) state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o   = 1'b0;
        capture_o  = 1'b0;
        ctr_load_o = 1'b0;
        ctr_val_o  = '0;
        ctr_dec_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_o   = start_i;
                ctr_load_o = start_i;
                ctr_val_o  = SETUP_LAST;
            end
            ST_SETUP: begin
                ctr_load_o = ctr_last_i;
                ctr_val_o  = ACCESS_LAST;
                ctr_dec_o  = !ctr_last_i;
            end
            ST_ACCESS: begin
                capture_o = ctr_last_i;
                ctr_dec_o = !ctr_last_i;
            end
            ST_DONE: begin
            end
            default: begin
            end
        endcase
    end

    assign state_o = state_q;

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_SETUP || $past(state_q) == ST_SETUP));
    // R7
    done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_ACCESS));
endmodule

// File: rtl/sbm_bus_path.sv
module sbm_bus_path
    import sbm_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sbm_state_e    state_i,
    input  logic          accept_i,
    input  logic          capture_i,
    input  logic          wr_sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] mem_din_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rdwr_o,
    output logic          mem_en_o,
    output logic [DW-1:0] mem_dout_o,
    output logic          mem_doe_o,
    output logic [DW-1:0] rdata_o
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          dir_q;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            dir_q   <= 1'b0;
        end else if (accept_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            dir_q   <= wr_sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   rdata_q <= '0;
        else if (capture_i && !dir_q) rdata_q <= mem_din_i;
    end

    assign active     = (state_i == ST_SETUP) || (state_i == ST_ACCESS);
    assign mem_addr_o = addr_q;
    assign mem_rdwr_o = (state_i != ST_IDLE) && dir_q;
    assign mem_en_o   = (state_i == ST_ACCESS);
    assign mem_doe_o  = active && dir_q;
    assign mem_dout_o = mem_doe_o ? wdata_q : '0;
    assign rdata_o    = rdata_q;

    // R6
    doe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe_o |-> mem_rdwr_o);
    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i || dir_q) |=> $stable(rdata_o));
endmodule

// File: rtl/strobe_mem_master.sv
module strobe_mem_master
    import sbm_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 8,
    parameter int SETUP_CYC  = 2,
    parameter int ACCESS_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          busy_o,
    output logic          mem_rdwr_o,
    output logic          mem_en_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_dout_o,
    output logic          mem_doe_o,
    input  logic [DW-1:0] mem_din_i
);
    localparam int MAXC = (SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    sbm_state_e    state;
    logic          accept, capture, ctr_load, ctr_dec, ctr_last;
    logic [CW-1:0] ctr_val;

    sbm_cycle_fsm #(.SETUP_CYC(SETUP_CYC), .ACCESS_CYC(ACCESS_CYC), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctr_last_i(ctr_last),
        .state_o(state), .accept_o(accept), .capture_o(capture),
        .ctr_load_o(ctr_load), .ctr_val_o(ctr_val), .ctr_dec_o(ctr_dec)
    );

    sbm_interval_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(ctr_load), .load_val_i(ctr_val),
        .dec_i(ctr_dec), .last_o(ctr_last)
    );

    sbm_bus_path #(.AW(AW), .DW(DW)) u_path (
        .clk(clk), .rst_n(rst_n), .state_i(state), .accept_i(accept),
        .capture_i(capture), .wr_sel_i(wr_sel_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .mem_din_i(mem_din_i), .mem_addr_o(mem_addr_o),
        .mem_rdwr_o(mem_rdwr_o), .mem_en_o(mem_en_o), .mem_dout_o(mem_dout_o),
        .mem_doe_o(mem_doe_o), .rdata_o(rdata_o)
    );

    assign busy_o = (state != ST_IDLE);
    assign done_o = (state == ST_DONE);

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(mem_addr_o) && $stable(mem_rdwr_o)));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    // R3
    done_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(mem_en_o));
    // R2
    en_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en_o) |-> ($past(busy_o) && !$past(mem_en_o)));
endmodule

// File: tb/tb_strobe_mem_master.sv
`timescale 1ns/1ps
module tb_strobe_mem_master;
    localparam int S = 2;
    localparam int A = 3;
    localparam int NV = 8;
    // {wr, addr[11:0], data[7:0]}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 12'h005, 8'h00},
        {1'b1, 12'h3A7, 8'h5C},
        {1'b0, 12'h3A7, 8'h00},
        {1'b1, 12'hFC1, 8'hA3},
        {1'b1, 12'h012, 8'hFF},
        {1'b0, 12'hFC1, 8'h00},
        {1'b0, 12'h83E, 8'h00},
        {1'b0, 12'h012, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, wr_sel = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, mem_dout, mem_din;
    logic done, busy, mem_rdwr, mem_en, mem_doe;
    logic [11:0] mem_addr;

    int checks = 0, fails = 0;
    logic [7:0] model [64];
    int en_cnt = 0;

    always #4 clk = ~clk;

    strobe_mem_master #(.SETUP_CYC(S), .ACCESS_CYC(A)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wr_sel_i(wr_sel),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
        .busy_o(busy), .mem_rdwr_o(mem_rdwr), .mem_en_o(mem_en),
        .mem_addr_o(mem_addr), .mem_dout_o(mem_dout), .mem_doe_o(mem_doe),
        .mem_din_i(mem_din)
    );

    always @(posedge clk) begin
        if (mem_en) en_cnt <= en_cnt + 1;
        else        en_cnt <= 0;
        if (mem_en && mem_rdwr && mem_doe) model[mem_addr[5:0]] <= mem_dout;
    end

    always_comb begin
        if (mem_en && (en_cnt == A - 1)) mem_din = model[mem_addr[5:0]];
        else                             mem_din = ~model[mem_addr[5:0]];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input bit wr, input logic [11:0] a, input logic [7:0] d,
                            input bit poke, input logic [7:0] exp_rd);
        int pre_en = 0, n_en = 0, done_at = 0, doe_bad = 0, stab_bad = 0, n_done = 0;
        logic [11:0] a0;
        logic r0;
        @(negedge clk);
        start = 1'b1; wr_sel = wr; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
        a0 = mem_addr; r0 = mem_rdwr;
        chk(a0 == a, "R2 addr", a0, a);
        chk(r0 == wr, "R9 dir", r0, wr);
        for (int k = 1; k <= 30; k++) begin
            if (k > 1) @(negedge clk);
            if (poke && k == 2) begin start = 1'b1; addr = a ^ 12'h0FF; wr_sel = ~wr; end
            else start = 1'b0;
            if (busy && (mem_addr != a0 || mem_rdwr != r0)) stab_bad++;
            if (mem_en) n_en++;
            else if (n_en == 0 && !done) pre_en++;
            if (k <= S + A) begin
                if (mem_doe != wr || (wr && mem_dout != d)) doe_bad++;
            end else if (mem_doe) doe_bad++;
            if (done) begin n_done++; if (done_at == 0) done_at = k; end
            if (!busy) break;
        end
        start = 1'b0;
        chk(pre_en == S, "R2 setup clocks", pre_en, S);
        chk(n_en == A, "R3 enable clocks", n_en, A);
        chk(stab_bad == 0, "R4 addr/dir stable", stab_bad, 0);
        chk(doe_bad == 0, "R6 data drive", doe_bad, 0);
        chk(done_at == S + A + 1 && n_done == 1, "R7 done pulse", done_at, S + A + 1);
        chk(!busy, "R7 busy low after done", busy, 0);
        chk(mem_rdwr == 1'b0, "R9 idle dir", mem_rdwr, 0);
        if (wr) chk(model[a[5:0]] == d, "R6 write stored", model[a[5:0]], d);
        chk(rdata == exp_rd, "R5 rdata", rdata, exp_rd);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!mem_en && !busy, "R8 no extra transfer", {mem_en, busy}, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] last_rd;
        for (int i = 0; i < 64; i++) model[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({mem_en, mem_doe, done, busy, mem_rdwr} == 5'b0, "R1 in reset",
            {mem_en, mem_doe, done, busy, mem_rdwr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mem_en, mem_doe, done, busy, mem_rdwr} == 5'b0, "R1 after reset",
            {mem_en, mem_doe, done, busy, mem_rdwr}, 0);
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);
        last_rd = 8'h00;
        for (int v = 0; v < NV; v++) begin
            logic [20:0] e;
            e = VEC[v];
            if (!e[20]) last_rd = model[e[13:8]];
            run_xfer(e[20], e[19:8], e[7:0], 1'b0, last_rd);
        end
        // R8 start pulses during a write and during a read are ignored
        run_xfer(1'b1, 12'h021, 8'h6D, 1'b1, last_rd);
        last_rd = model[6'h21];
        run_xfer(1'b0, 12'h021, 8'h00, 1'b1, last_rd);
        chk(last_rd == 8'h6D, "R5 readback", last_rd, 8'h6D);
        // R1 reset mid-transfer
        @(negedge clk);
        start = 1'b1; wr_sel = 1'b1; addr = 12'h044; wdata = 8'h11;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({mem_en, mem_doe, busy, mem_rdwr} == 4'b0, "R1 reset aborts",
            {mem_en, mem_doe, busy, mem_rdwr}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule